// File: doc/BRIEF.md
# RTC Interrupt Flag Aggregator

This block gathers single-cycle event pulses from three independent interrupt sources of a real-time clock: periodic, alarm and update-ended. It records them in an 8-bit status byte that clears when read. Each source owns one flag bit. A flag is set by its event whatever the state of that source's enable input, so software can poll the flags with interrupts masked. The active-low request line is asserted whenever some source has both its flag and its enable set. Bit 7 of the status byte mirrors that condition as a summary bit.

The host bus decoder frames each status read with a start strobe and an end strobe. From the start of a read until its end, the status byte shown to the bus is frozen. Events that arrive in that window are parked in a per-source pending latch. When the read closes, every flag that was shown is cleared. The parked events, and any event arriving on the closing edge itself, are then loaded, so no event is lost. The event generators, the bus decoder and the storage of the enable bits are outside this block.

There is no streaming data path here. The read strobes, enables and event pulses are plain control pins with no back-pressure. Every pulse is taken on the clock edge where it is high.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset, `status_o` is 0x00, `irq_n_o` is 1 and no read is in progress.
- R2: A high `ev_i[k]` on an edge outside a read sets flag k from the next cycle on, regardless of `en_i[k]`. Source index 0 (update-ended) shows in status bit 4, index 1 (alarm) in bit 5 and index 2 (periodic) in bit 6. Bits 3 to 0 always read 0.
- R3: `irq_n_o` is 0 in exactly those cycles where some k has flag k and `en_i[k]` both 1. This is combinational in the enables, so raising an enable while its flag is already set asserts the line in the same cycle.
- R4: Outside a read, status bit 7 is 1 exactly when `irq_n_o` is 0.
- R5: A read begins with `rd_start_i` high on an edge. From the next cycle until the read closes, `status_o` keeps the value it had in the `rd_start_i` cycle, even while events arrive or enables change.
- R6: A read closes on the first edge, from the `rd_start_i` edge on, where `rd_end_i` is high. That edge clears every flag and with them bit 7. A start and end on the same edge form a one-cycle read.
- R7: An event that arrives during a read, from the start edge up to the edge before the close, leaves `status_o` unchanged during the read. Its flag is set on the closing edge.
- R8: An event on the closing edge of a read sets its flag after the clear.
- R9: Any combination of the three flags can be set at once. All three set together with all enables high reads 0xF0.
- R10: `rd_end_i` high while no read is in progress and `rd_start_i` is low is ignored. The flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start_i | input | 1 | Status read begins (pulse) |
| rd_end_i | input | 1 | Status read ends (pulse) |
| en_i | input | 3 | Per-source interrupt enables (0 update-ended, 1 alarm, 2 periodic) |
| ev_i | input | 3 | Per-source event pulses, same index order |
| status_o | output | 8 | Status byte: bit 7 summary, bits 6..4 flags, bits 3..0 zero |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands inside an open read. There it must be parked, kept off the frozen byte, and surface exactly once after the clear. A closely related case is an event on the closing edge itself. The bench holds a read open for several cycles. It fires an event and changes an enable in the middle of the read and checks that the byte does not move. It then closes the read and checks that only the parked source remains. A separate scenario fires a pulse on the very cycle that `rd_end_i` is high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned NUM_SRC  = 3;
  parameter int unsigned STAT_W   = 8;
  parameter int unsigned FLAG_LSB = 4;
  parameter int unsigned SUM_BIT  = 7;
endpackage

// File: rtl/irq_rd_seq.sv
module irq_rd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start_i,
  input  logic rd_end_i,
  output logic in_read_o,
  output logic rd_active_o,
  output logic rd_close_o
);
  logic in_read_q;

  assign rd_active_o = rd_start_i | in_read_q;
  assign rd_close_o  = rd_end_i & rd_active_o;
  assign in_read_o   = in_read_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          in_read_q <= 1'b0;
    else if (rd_close_o) in_read_q <= 1'b0;
    else if (rd_start_i) in_read_q <= 1'b1;
  end

  // R10
  stray_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end_i && !rd_start_i && !in_read_q) |=> !in_read_q);

  // R6
  open_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start_i && !rd_end_i) |=> in_read_q);
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic rd_active_i,
  input  logic rd_close_i,
  output logic flag_o
);
  logic flag_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (rd_close_i) begin
      flag_q <= pend_q | ev_i;
      pend_q <= 1'b0;
    end else if (rd_active_i) begin
      pend_q <= pend_q | ev_i;
    end else if (ev_i) begin
      flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R2
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !rd_active_i) |=> flag_q);

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active_i && !rd_close_i) |=> $stable(flag_q));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_close_i && !ev_i && !pend_q) |=> !flag_q);

  // R8
  end_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_close_i && ev_i) |=> flag_q);
endmodule

// File: rtl/irq_status_view.sv
module irq_status_view
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   flags_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic              rd_start_i,
  input  logic              in_read_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_n_o
);
  logic              irqf;
  logic [STAT_W-1:0] live;
  logic [STAT_W-1:0] snap_q;

  assign irqf = |(flags_i & en_i);

  always_comb begin
    live = '0;
    live[SUM_BIT] = irqf;
    live[FLAG_LSB +: NSRC] = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       snap_q <= '0;
    else if (rd_start_i && !in_read_i) snap_q <= live;
  end

  assign status_o = in_read_i ? snap_q : live;
  assign irq_n_o  = ~irqf;

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read_i && $past(in_read_i)) |-> $stable(status_o));

  // R5
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start_i && !in_read_i) |=> (!in_read_i || status_o == $past(live)));

  // R4
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_read_i |-> (status_o[SUM_BIT] == !irq_n_o));
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start_i,
  input  logic              rd_end_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   ev_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_n_o
);
  logic            in_read;
  logic            rd_active;
  logic            rd_close;
  logic [NSRC-1:0] flags;

  irq_rd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start_i (rd_start_i),
    .rd_end_i   (rd_end_i),
    .in_read_o  (in_read),
    .rd_active_o(rd_active),
    .rd_close_o (rd_close)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    irq_flag_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev_i[k]),
      .rd_active_i(rd_active),
      .rd_close_i (rd_close),
      .flag_o     (flags[k])
    );
  end

  irq_status_view #(.NSRC(NSRC)) u_view (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_i   (flags),
    .en_i      (en_i),
    .rd_start_i(rd_start_i),
    .in_read_i (in_read),
    .status_o  (status_o),
    .irq_n_o   (irq_n_o)
  );

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (|(status_o[FLAG_LSB +: NSRC] & en_i)) || in_read);

  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[FLAG_LSB-1:0] == '0);
endmodule

// File: tb/tb_irq_flag_agg.sv
`timescale 1ns/1ps
module tb_irq_flag_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_start = 1'b0;
  logic       rd_end = 1'b0;
  logic [2:0] en = 3'b000;
  logic [2:0] ev = 3'b000;
  logic [7:0] status;
  logic       irq_n;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_flag_agg dut (
    .clk(clk), .rst_n(rst_n), .rd_start_i(rd_start), .rd_end_i(rd_end),
    .en_i(en), .ev_i(ev), .status_o(status), .irq_n_o(irq_n)
  );

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input logic [7:0] exp_st, input logic exp_irq, input string tag);
    checks++;
    if (status !== exp_st || irq_n !== exp_irq) begin
      fails++;
      $display("FAIL %s status=%02h irq_n=%b expected status=%02h irq_n=%b",
               tag, status, irq_n, exp_st, exp_irq);
    end
  endtask

  task automatic pulse(input logic [2:0] m); ev = m; tick(); ev = 3'b000; endtask

  task automatic quick_read; rd_start = 1; rd_end = 1; tick(); rd_start = 0; rd_end = 0; endtask

  task automatic t_reset;
    chk(8'h00, 1'b1, "R1 reset state");
  endtask

  task automatic t_poll;
    en = 3'b000;
    pulse(3'b010);
    chk(8'h20, 1'b1, "R2 alarm flag while masked");
    rd_end = 1; tick(); rd_end = 0;
    chk(8'h20, 1'b1, "R10 stray end keeps flag");
  endtask

  task automatic t_enable_late;
    en = 3'b010; #1;
    chk(8'hA0, 1'b0, "R3 R4 enable over set flag");
  endtask

  task automatic t_read_clear;
    rd_start = 1; tick(); rd_start = 0;
    chk(8'hA0, 1'b0, "R5 byte during read");
    tick();
    chk(8'hA0, 1'b0, "R5 byte held");
    rd_end = 1; tick(); rd_end = 0;
    chk(8'h00, 1'b1, "R6 cleared after read");
    en = 3'b000;
  endtask

  task automatic t_defer;
    pulse(3'b100);
    chk(8'h40, 1'b1, "R2 periodic flag");
    rd_start = 1; tick(); rd_start = 0;
    ev = 3'b001; en = 3'b100; tick(); ev = 3'b000;
    chk(8'h40, 1'b0, "R7 R5 event and enable during read");
    tick();
    chk(8'h40, 1'b0, "R7 still frozen");
    rd_end = 1; tick(); rd_end = 0;
    chk(8'h10, 1'b1, "R7 parked event after close");
    en = 3'b000; quick_read();
    chk(8'h00, 1'b1, "R6 one-cycle read clears");
  endtask

  task automatic t_end_edge;
    pulse(3'b100);
    rd_start = 1; tick(); rd_start = 0;
    rd_end = 1; ev = 3'b010; tick(); rd_end = 0; ev = 3'b000;
    chk(8'h20, 1'b1, "R8 event on closing edge kept");
    quick_read();
  endtask

  task automatic t_multi;
    en = 3'b111;
    pulse(3'b111);
    chk(8'hF0, 1'b0, "R9 all three flags");
    en = 3'b000; #1;
    chk(8'h70, 1'b1, "R3 all masked");
    en = 3'b001; #1;
    chk(8'hF0, 1'b0, "R3 single enable");
    quick_read();
    chk(8'h00, 1'b1, "R6 all cleared");
    en = 3'b000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_poll();
    t_enable_late();
    t_read_clear();
    t_defer();
    t_end_edge();
    t_multi();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule